// File: doc/BRIEF.md
# Two-level prioritized interrupt controller

This block collects single-cycle interrupt requests from a set of peripheral sources and presents one registered interrupt request level to a processor core. Each source owns a flag, which is set by the source's request, and an enable bit. Among the sources whose flag and enable are both set, a fixed-priority arbiter picks one winner. The lowest source index has the highest priority. The winner's group then raises a pending bit in a CPU-level pending register.

A pending bit reaches the core only when the same bit is set in the group mask register and the global mode bit is clear. The global mode bit sits in a status word. It is set by reset and by every hardware acknowledge, and software can set or clear it at will. When the core acknowledges, the block serves the current winner. It loads that source's vector offset into the readable vector register, clears the source's flag and clears its group's pending bit. If no source is active at that moment, the block loads a phantom offset of zero instead and drops every pending bit. An acknowledge marked as a software trap does all of this but leaves the global mode bit alone.

Top module: `irq_prio_ctl`

## Requirements
- R1: A request pulse on `src_req[i]` sets `src_flag[i]` at the next clock edge, whether or not source i is enabled.
- R2: A 1 on `flag_w1c[i]` clears `src_flag[i]` at the next edge. A 0 leaves the flag unchanged. If a request for the same source arrives in the same cycle as a clear (from `flag_w1c` or from an acknowledge), the request wins and the flag stays 1.
- R3: A source is active when its flag and its enable bit (loaded from `en_wdata` when `en_we` is 1) are both 1. The active source with the lowest index wins and sets `pend[g]` one edge later. By default, group g holds sources 2g and 2g+1.
- R4: At most one bit of `pend` goes from 0 to 1 at any edge.
- R5: `cpu_irq` is a registered level. At each edge it takes the value 1 exactly when, before that edge, some bit of `pend` and the matching mask bit (loaded from `msk_wdata` when `msk_we` is 1) were both 1 and the mode bit was 0.
- R6: `stat_reg` bit 9 holds the global mode bit, and all other bits of `stat_reg` read 0. At each edge the mode bit is updated in this order: an acknowledge with `ack_trap` low forces it to 1; otherwise `mode_set` sets it to 1; otherwise `mode_clr` clears it to 0.
- R7: An acknowledge with `ack_trap` high does not change the mode bit. In that cycle the bit follows `mode_set` and `mode_clr` only.
- R8: On an acknowledge with an active source w, the next edge loads `vec_ofs` with 0x0010 + 2·w, clears `src_flag[w]` (subject to R2) and clears the pending bit of w's group. The mask and the mode bit have no effect on this.
- R9: On an acknowledge with no active source, the next edge loads `vec_ofs` with 0x0000 and clears every bit of `pend`.
- R10: After reset, flags, enables, masks, `pend`, `cpu_irq` and `vec_ofs` are 0, and the mode bit is 1, so `stat_reg` reads 0x0200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Per-source request pulses |
| flag_w1c | input | NUM_SRC | Write-one-to-clear strobes for source flags |
| en_we | input | 1 | Load source enable register |
| en_wdata | input | NUM_SRC | New source enable value |
| msk_we | input | 1 | Load group mask register |
| msk_wdata | input | NUM_GRP | New group mask value |
| mode_set | input | 1 | Software set of the global mode bit |
| mode_clr | input | 1 | Software clear of the global mode bit |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_trap | input | 1 | Qualifies `ack` as a software trap |
| src_flag | output | NUM_SRC | Source flag register |
| pend | output | NUM_GRP | CPU-level pending register |
| cpu_irq | output | 1 | Registered request to the core |
| stat_reg | output | STAT_W | Status word holding the mode bit |
| vec_ofs | output | OFS_W | Vector offset register |

## Verification
The hardest states to reach from the ports are the collisions. One is an acknowledge that lands while pending bits are set but no source is active any longer, which produces a phantom zero offset and a full pending clear. Another is a request that arrives in the same cycle as its own flag's clear. The stimulus sweeps all 256 enable patterns with every source requesting. It then acknowledges more times than there are enabled sources, so each sweep step drains the winners in priority order and always ends in a phantom acknowledge. Directed sequences add same-cycle request and clear pairs, and acknowledge against `mode_clr` with and without the trap qualifier, over all mask values.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // Group that owns a source: contiguous blocks or interleaved by index.
   function automatic int src_grp(input int idx, input int per_grp,
                                  input int n_grp, input bit interleave);
      return interleave ? (idx % n_grp) : (idx / per_grp);
   endfunction

   // Vector offset of a source: base plus a fixed stride per index.
   function automatic int vec_of(input int idx, input int base, input int step);
      return base + idx * step;
   endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] flag_w1c,
   input  logic [NUM_SRC-1:0] svc_clr,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] src_flag,
   output logic [NUM_SRC-1:0] src_act
);

   logic [NUM_SRC-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      logic flag_q;
      // A new request outranks any clear arriving in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= src_req[i] | (flag_q & ~flag_w1c[i] & ~svc_clr[i]);
      end
      assign src_flag[i] = flag_q;
      assign src_act[i]  = flag_q & en_q[i];
   end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int NUM_SRC    = 8,
   parameter int ARB_ONEHOT = 0,
   localparam int IDX_W     = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] act,
   output logic               win_vld,
   output logic [IDX_W-1:0]   win_idx,
   output logic [NUM_SRC-1:0] win_oh
);

   assign win_vld = |act;

   if (ARB_ONEHOT == 0) begin : g_scan
      // Downward scan: the last hit written is the lowest index.
      always_comb begin
         win_idx = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act[i]) win_idx = IDX_W'(i);
         end
      end
      always_comb begin
         win_oh = '0;
         if (win_vld) win_oh[win_idx] = 1'b1;
      end
   end else begin : g_isolate
      // Isolate the lowest set bit, then encode it.
      assign win_oh = act & (~act + 1'b1);
      always_comb begin
         win_idx = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (win_oh[i]) win_idx = win_idx | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate #(
   parameter int NUM_GRP  = 4,
   parameter int STAT_W   = 16,
   parameter int MODE_BIT = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GRP-1:0] grp_set,
   input  logic [NUM_GRP-1:0] grp_clr,
   input  logic               msk_we,
   input  logic [NUM_GRP-1:0] msk_wdata,
   input  logic               mode_set,
   input  logic               mode_clr,
   input  logic               hw_ack,
   output logic [NUM_GRP-1:0] pend,
   output logic [NUM_GRP-1:0] msk,
   output logic               cpu_irq,
   output logic [STAT_W-1:0]  stat_reg
);

   logic [NUM_GRP-1:0] pend_q;
   logic [NUM_GRP-1:0] msk_q;
   logic               mode_q;
   logic               irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q | grp_set) & ~grp_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk_q <= '0;
      else if (msk_we) msk_q <= msk_wdata;
   end

   // Hardware acknowledge outranks software writes to the mode bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= 1'b1;
      else if (hw_ack)   mode_q <= 1'b1;
      else if (mode_set) mode_q <= 1'b1;
      else if (mode_clr) mode_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (|(pend_q & msk_q)) & ~mode_q;
   end

   always_comb begin
      stat_reg           = '0;
      stat_reg[MODE_BIT] = mode_q;
   end

   assign pend    = pend_q;
   assign msk     = msk_q;
   assign cpu_irq = irq_q;

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
   parameter int NUM_SRC        = 8,
   parameter int NUM_GRP        = 4,
   parameter int GRP_INTERLEAVE = 0,
   parameter int ARB_ONEHOT     = 0,
   parameter int OFS_W          = 16,
   parameter int VEC_BASE       = 16,
   parameter int VEC_STEP       = 2,
   parameter int STAT_W         = 16,
   parameter int MODE_BIT       = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] flag_w1c,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic               msk_we,
   input  logic [NUM_GRP-1:0] msk_wdata,
   input  logic               mode_set,
   input  logic               mode_clr,
   input  logic               ack,
   input  logic               ack_trap,
   output logic [NUM_SRC-1:0] src_flag,
   output logic [NUM_GRP-1:0] pend,
   output logic               cpu_irq,
   output logic [STAT_W-1:0]  stat_reg,
   output logic [OFS_W-1:0]   vec_ofs
);

   localparam int IDX_W       = $clog2(NUM_SRC);
   localparam int SRC_PER_GRP = NUM_SRC / NUM_GRP;
   localparam int VEC_MAX     = irq_prio_pkg::vec_of(NUM_SRC - 1, VEC_BASE, VEC_STEP);

   // Elaboration-time parameter checks.
   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_prio_ctl: NUM_SRC must be at least 2");
   end
   if (NUM_GRP < 1 || (NUM_SRC % NUM_GRP) != 0) begin : g_bad_grp
      $error("irq_prio_ctl: NUM_GRP must divide NUM_SRC");
   end
   if (VEC_BASE < 1 || VEC_STEP < 1) begin : g_bad_vec
      $error("irq_prio_ctl: vector offsets must be non-zero and increasing");
   end
   if (OFS_W < 2 || OFS_W > 30 || (VEC_MAX >> OFS_W) != 0) begin : g_bad_ofs
      $error("irq_prio_ctl: OFS_W too narrow for the vector offsets");
   end
   if (MODE_BIT >= STAT_W) begin : g_bad_mode
      $error("irq_prio_ctl: MODE_BIT outside the status word");
   end

   logic [NUM_SRC-1:0] src_act;
   logic [NUM_SRC-1:0] svc_clr;
   logic               win_vld;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_SRC-1:0] win_oh;
   logic [NUM_GRP-1:0] grp_set;
   logic [NUM_GRP-1:0] grp_clr;
   logic [NUM_GRP-1:0] msk;
   logic [OFS_W-1:0]   vec_calc;
   logic [OFS_W-1:0]   vec_q;
   logic               hw_ack;

   assign svc_clr = ack ? win_oh : '0;
   assign hw_ack  = ack & ~ack_trap;

   irq_src_bank #(
      .NUM_SRC (NUM_SRC)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_req  (src_req),
      .flag_w1c (flag_w1c),
      .svc_clr  (svc_clr),
      .en_we    (en_we),
      .en_wdata (en_wdata),
      .src_flag (src_flag),
      .src_act  (src_act)
   );

   irq_prio_arb #(
      .NUM_SRC    (NUM_SRC),
      .ARB_ONEHOT (ARB_ONEHOT)
   ) u_arb (
      .act     (src_act),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_oh  (win_oh)
   );

   // Fold the winning source onto its group.
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [NUM_SRC-1:0] memb;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_memb
         assign memb[i] = (irq_prio_pkg::src_grp(i, SRC_PER_GRP, NUM_GRP,
                                                 GRP_INTERLEAVE != 0) == g);
      end
      assign grp_set[g] = |(win_oh & memb);
   end

   // A real acknowledge retires the winner's group; a phantom one retires all.
   assign grp_clr = !ack ? '0 : (win_vld ? grp_set : {NUM_GRP{1'b1}});

   irq_cpu_gate #(
      .NUM_GRP  (NUM_GRP),
      .STAT_W   (STAT_W),
      .MODE_BIT (MODE_BIT)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .grp_set   (grp_set),
      .grp_clr   (grp_clr),
      .msk_we    (msk_we),
      .msk_wdata (msk_wdata),
      .mode_set  (mode_set),
      .mode_clr  (mode_clr),
      .hw_ack    (hw_ack),
      .pend      (pend),
      .msk       (msk),
      .cpu_irq   (cpu_irq),
      .stat_reg  (stat_reg)
   );

   always_comb begin
      vec_calc = OFS_W'(irq_prio_pkg::vec_of(int'(win_idx), VEC_BASE, VEC_STEP));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vec_q <= '0;
      else if (ack) vec_q <= win_vld ? vec_calc : '0;
   end

   assign vec_ofs = vec_q;

endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk #(
   parameter int NUM_SRC  = 8,
   parameter int NUM_GRP  = 4,
   parameter int OFS_W    = 16,
   parameter int STAT_W   = 16,
   parameter int MODE_BIT = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic               ack,
   input logic               ack_trap,
   input logic [NUM_SRC-1:0] src_flag,
   input logic [NUM_SRC-1:0] act,
   input logic               win_vld,
   input logic [NUM_GRP-1:0] pend,
   input logic [NUM_GRP-1:0] msk,
   input logic               cpu_irq,
   input logic [STAT_W-1:0]  stat_reg,
   input logic [OFS_W-1:0]   vec_ofs
);

   a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req != '0) |=> ((src_flag & $past(src_req)) == $past(src_req)));

   a_r3_pend_follows_winner: assert property (@(posedge clk) disable iff (!rst_n)
      (win_vld && !ack) |=> (pend != '0));

   a_r4_one_new_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pend & ~$past(pend)) <= 1);

   a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> $past(((pend & msk) != '0) && !stat_reg[MODE_BIT]));

   a_r7_hw_ack_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_trap) |=> stat_reg[MODE_BIT]);

   a_r8_real_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && act != '0) |=> (vec_ofs != '0));

   a_r9_phantom_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && act == '0) |=> (vec_ofs == '0 && pend == '0));

endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(
   .NUM_SRC  (NUM_SRC),
   .NUM_GRP  (NUM_GRP),
   .OFS_W    (OFS_W),
   .STAT_W   (STAT_W),
   .MODE_BIT (MODE_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_req  (src_req),
   .ack      (ack),
   .ack_trap (ack_trap),
   .src_flag (src_flag),
   .act      (src_act),
   .win_vld  (win_vld),
   .pend     (pend),
   .msk      (msk),
   .cpu_irq  (cpu_irq),
   .stat_reg (stat_reg),
   .vec_ofs  (vec_ofs)
);

// File: tb/irq_prio_ctl_bench.sv
module irq_prio_ctl_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_req = '0;
   logic [7:0]  flag_w1c = '0;
   logic        en_we = 1'b0;
   logic [7:0]  en_wdata = '0;
   logic        msk_we = 1'b0;
   logic [3:0]  msk_wdata = '0;
   logic        mode_set = 1'b0;
   logic        mode_clr = 1'b0;
   logic        ack = 1'b0;
   logic        ack_trap = 1'b0;
   logic [7:0]  src_flag;
   logic [3:0]  pend;
   logic        cpu_irq;
   logic [15:0] stat_reg;
   logic [15:0] vec_ofs;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Reference state, derived from the requirements.
   logic [7:0]  m_flag = '0;
   logic [7:0]  m_en   = '0;
   logic [3:0]  m_msk  = '0;
   logic [3:0]  m_pend = '0;
   logic        m_mode = 1'b1;
   logic        m_irq  = 1'b0;
   logic [15:0] m_vec  = '0;

   always #(CLK_P / 2) clk = ~clk;

   irq_prio_ctl u_irq_prio_ctl (
      .clk (clk), .rst_n (rst_n), .src_req (src_req), .flag_w1c (flag_w1c),
      .en_we (en_we), .en_wdata (en_wdata), .msk_we (msk_we),
      .msk_wdata (msk_wdata), .mode_set (mode_set), .mode_clr (mode_clr),
      .ack (ack), .ack_trap (ack_trap), .src_flag (src_flag), .pend (pend),
      .cpu_irq (cpu_irq), .stat_reg (stat_reg), .vec_ofs (vec_ofs)
   );

   task automatic check(input string tag, input logic [31:0] act_v,
                        input logic [31:0] exp_v);
      n_cmp++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
      end
   endtask

   function automatic int lowest(input logic [7:0] v);
      int lo = 0;
      for (int i = 7; i >= 0; i--) if (v[i]) lo = i;
      return lo;
   endfunction

   // One clock: predict, step, compare at the following falling edge.
   task automatic tick();
      logic [7:0]  a;
      logic        vld;
      int          w;
      logic [7:0]  nflag;
      logic [3:0]  gset, gclr, npend, prev_pend;
      logic        nmode, nirq;
      logic [15:0] nvec;
      a     = m_flag & m_en;
      vld   = (a != 0);
      w     = lowest(a);
      nflag = (m_flag & ~flag_w1c & ~((ack && vld) ? (8'b1 << w) : 8'b0)) | src_req;
      gset  = vld ? (4'b1 << (w / 2)) : 4'b0;
      gclr  = ack ? (vld ? gset : 4'hF) : 4'b0;
      npend = (m_pend | gset) & ~gclr;
      nirq  = ((m_pend & m_msk) != 0) && !m_mode;
      nmode = (ack && !ack_trap) ? 1'b1 : mode_set ? 1'b1 : mode_clr ? 1'b0 : m_mode;
      nvec  = ack ? (vld ? 16'(16 + 2 * w) : 16'h0000) : m_vec;
      prev_pend = pend;
      @(posedge clk);
      @(negedge clk);
      m_flag = nflag;
      if (en_we)  m_en  = en_wdata;
      if (msk_we) m_msk = msk_wdata;
      m_pend = npend;
      m_irq  = nirq;
      m_mode = nmode;
      m_vec  = nvec;
      check("R1/R2 src_flag", 32'(src_flag), 32'(m_flag));
      check("R3 pend", 32'(pend), 32'(m_pend));
      check("R4 new pend bits <= 1", 32'($countones(pend & ~prev_pend) <= 1), 32'd1);
      check("R5 cpu_irq", 32'(cpu_irq), 32'(m_irq));
      check("R6/R7 stat_reg", 32'(stat_reg), 32'({6'b0, m_mode, 9'b0}));
      check(vld ? "R8 vec_ofs" : "R9 vec_ofs", 32'(vec_ofs), 32'(m_vec));
      src_req = '0; flag_w1c = '0; en_we = 1'b0; msk_we = 1'b0;
      mode_set = 1'b0; mode_clr = 1'b0; ack = 1'b0; ack_trap = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 src_flag", 32'(src_flag), 32'h0);
      check("R10 pend", 32'(pend), 32'h0);
      check("R10 cpu_irq", 32'(cpu_irq), 32'h0);
      check("R10 stat_reg", 32'(stat_reg), 32'h0200);
      check("R10 vec_ofs", 32'(vec_ofs), 32'h0);

      // R6: software control of the mode bit at bit 9
      mode_clr = 1'b1; tick();
      check("R6 mode cleared", 32'(stat_reg), 32'h0000);
      mode_set = 1'b1; tick();
      check("R6 mode set", 32'(stat_reg), 32'h0200);
      msk_we = 1'b1; msk_wdata = 4'hF; tick();

      // R3, R8, R9: every enable pattern with all sources requesting,
      // drained by more acknowledges than sources.
      for (int e = 0; e < 256; e++) begin
         en_we = 1'b1; en_wdata = 8'(e); tick();
         src_req = 8'hFF; tick();
         mode_clr = 1'b1; tick();
         tick();
         for (int k = 0; k < 9; k++) begin
            ack = 1'b1; ack_trap = k[0]; tick();
            mode_clr = 1'b1; tick();
         end
         flag_w1c = 8'hFF; tick();
      end

      // R2: request and clear of the same flag in one cycle
      en_we = 1'b1; en_wdata = 8'h00; tick();
      src_req = 8'h04; tick();
      src_req = 8'h04; flag_w1c = 8'h04; tick();
      check("R2 set beats w1c", 32'(src_flag[2]), 32'd1);
      flag_w1c = 8'h04; tick();
      check("R2 w1c clears", 32'(src_flag[2]), 32'd0);
      flag_w1c = 8'hFF; tick();
      check("R2 w1c on clear flags", 32'(src_flag), 32'h0);

      // R8 with R2: acknowledge of a source that requests again
      en_we = 1'b1; en_wdata = 8'h04; tick();
      src_req = 8'h04; tick();
      tick();
      ack = 1'b1; src_req = 8'h04; tick();
      check("R8 vector of source 2", 32'(vec_ofs), 32'h0014);
      check("R2 request beats service clear", 32'(src_flag[2]), 32'd1);

      // R7: acknowledge against a software clear, with and without trap
      mode_clr = 1'b1; tick();
      ack = 1'b1; mode_clr = 1'b1; tick();
      check("R7 hardware ack outranks clear", 32'(stat_reg[9]), 32'd1);
      ack = 1'b1; ack_trap = 1'b1; mode_clr = 1'b1; tick();
      check("R7 trap ack leaves clear", 32'(stat_reg[9]), 32'd0);
      ack = 1'b1; ack_trap = 1'b1; tick();
      check("R7 trap ack keeps mode", 32'(stat_reg[9]), 32'd0);
      check("R9 phantom offset", 32'(vec_ofs), 32'h0);

      // R5: every mask value, with one source per group requesting
      en_we = 1'b1; en_wdata = 8'hFF; tick();
      for (int m = 0; m < 16; m++) begin
         msk_we = 1'b1; msk_wdata = 4'(m); src_req = 8'h55; mode_clr = 1'b1; tick();
         tick(); tick();
         ack = 1'b1; ack_trap = 1'b1; tick();
         tick();
         ack = 1'b1; ack_trap = 1'b1; tick();
         mode_set = 1'b1; tick();
         tick();
         flag_w1c = 8'hFF; ack = 1'b1; tick();
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule